// File: doc/BRIEF.md
# Multi-Partition Spike Report Validator

A spike-sorting engine that is folded in time works through its electrode partitions one after another inside each sampling period. A neuron that sits in a zone shared by several partitions can therefore be reported once per partition that contains it. A spike induced by a neighbour near a partition edge shows up in only some of those partitions. This block accepts a spike for such a shared neuron only when every partition that holds the neuron has reported it. The reports do not have to arrive in the same sampling period. They may be spread over a short, programmable number of sampling periods, which absorbs detection jitter.

Each neuron has a span value in a small table. The span says how many partitions the neuron belongs to. A neuron with a span of one is forwarded at once. For a shared neuron, the block keeps a pending entry with one bit per fold that has reported it, plus an age counted in sampling ticks. The entry produces a single confirmed spike when the number of distinct reporting folds reaches the span. The entry is dropped if its window runs out first. Confirmed IDs leave as a one-cycle strobe with an ID.

Top module: `spike_span_validator`

## Requirements
- R1: Right after reset, `spkValid` is low and every neuron's span code is 0.
- R2: A write with `cfgWe` high stores `cfgSpan` for neuron `cfgId`. A span code c means the neuron belongs to c+1 partitions, so codes 0..3 stand for 1..4 partitions.
- R3: A report for a neuron with span code 0 drives `spkValid` high with `spkId` equal to the reported ID in the next clock cycle. It never waits for other folds.
- R4: For a neuron with span code c > 0, a confirmation is emitted when reports from c+1 distinct fold indices have been collected in the open window. `spkValid` goes high with `spkId` equal to the neuron one clock cycle after the report that completes the set.
- R5: A repeated report from a fold index that is already recorded in the neuron's open entry does not add to the count.
- R6: An entry opens with the first report for the neuron and age 0. Every `sampleTick` raises its age. When a tick would bring the age to `winLen`, the entry is discarded without output. A report in the same cycle as that tick is still counted first. A `winLen` of 0 behaves like 1.
- R7: After a confirmation, the neuron's entry is empty. Later reports start a new set, and each confirmation gives exactly one output pulse.
- R8: Reports for one neuron that lie in different sampling periods are combined, provided they fall within the window of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle pulse marking the end of a sampling period |
| winLen | input | AGE_W | Window length in sampling ticks |
| cfgWe | input | 1 | Span table write strobe |
| cfgId | input | ID_W | Neuron whose span is written |
| cfgSpan | input | SPAN_W | Span code (partitions minus one) |
| rptValid | input | 1 | Fold report strobe |
| rptId | input | ID_W | Reported neuron ID |
| rptFold | input | FOLD_W | Index of the fold that produced the report |
| spkValid | output | 1 | Validated spike strobe |
| spkId | output | ID_W | Validated neuron ID |

## Verification
The bench builds the block with 8 neurons, 4 folds and a 4-bit age. With 4 folds, every span from one to four partitions can be reached, and every fold index can be repeated or left out. The window is run at 3 and then at 1. This covers reports straddling two tick boundaries, expiry in the middle of a set, and a report arriving on the very tick that closes the window. Duplicate folds, re-arming after a confirmation and the bypass path are all compared cycle by cycle against a behavioural model.

// File: rtl/spkval_pkg.sv
package spkval_pkg;
  typedef struct packed {
    logic fire;       // an output spike is due next cycle
    logic viaBypass;  // the spike comes from a single-partition neuron
  } vldStrobe_t;
endpackage

// File: rtl/spkval_dpath.sv
module spkval_dpath #(
  parameter int NUM_NEURONS = 8,
  parameter int NUM_FOLDS   = 4,
  localparam int ID_W   = $clog2(NUM_NEURONS),
  localparam int SPAN_W = $clog2(NUM_FOLDS),
  localparam int CNT_W  = $clog2(NUM_FOLDS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWe,
  input  logic [ID_W-1:0]           cfgId,
  input  logic [SPAN_W-1:0]         cfgSpan,
  input  logic [ID_W-1:0]           rptId,
  input  spkval_pkg::vldStrobe_t    strobe,
  output logic [CNT_W-1:0]          needCnt,
  output logic                      spkValid,
  output logic [ID_W-1:0]           spkId
);
  logic [SPAN_W-1:0] spanTbl [NUM_NEURONS];

  for (genvar i = 0; i < NUM_NEURONS; i++) begin : g_span
    always_ff @(posedge clk) begin
      if (!rstN) spanTbl[i] <= '0;
      else if (cfgWe && cfgId == ID_W'(i)) spanTbl[i] <= cfgSpan;
    end
  end

  assign needCnt = CNT_W'(spanTbl[rptId]) + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spkValid <= 1'b0;
      spkId    <= '0;
    end else begin
      spkValid <= strobe.fire;
      if (strobe.fire) spkId <= rptId;
    end
  end
endmodule

// File: rtl/spkval_ctrl.sv
module spkval_ctrl #(
  parameter int NUM_NEURONS = 8,
  parameter int NUM_FOLDS   = 4,
  parameter int AGE_W       = 4,
  localparam int ID_W   = $clog2(NUM_NEURONS),
  localparam int FOLD_W = $clog2(NUM_FOLDS),
  localparam int CNT_W  = $clog2(NUM_FOLDS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleTick,
  input  logic [AGE_W-1:0]       winLen,
  input  logic                   rptValid,
  input  logic [ID_W-1:0]        rptId,
  input  logic [FOLD_W-1:0]      rptFold,
  input  logic [CNT_W-1:0]       needCnt,
  output spkval_pkg::vldStrobe_t strobe
);
  logic [NUM_FOLDS-1:0]   foldBit;
  logic                   shared;
  logic [NUM_NEURONS-1:0] doneVec;

  assign foldBit = NUM_FOLDS'(1) << rptFold;
  assign shared  = needCnt > CNT_W'(1);

  for (genvar i = 0; i < NUM_NEURONS; i++) begin : g_entry
    logic                 activeQ;
    logic [NUM_FOLDS-1:0] seenQ;
    logic [AGE_W-1:0]     ageQ;
    logic                 hit, done, expire;
    logic [NUM_FOLDS-1:0] newMask;
    logic [CNT_W-1:0]     cnt;
    logic [AGE_W-1:0]     effAge;
    logic [AGE_W:0]       ageNext;

    always_comb begin
      hit     = rptValid && shared && rptId == ID_W'(i);
      newMask = seenQ | (hit ? foldBit : '0);
      cnt     = CNT_W'($countones(newMask));
      done    = hit && cnt >= needCnt;
      effAge  = activeQ ? ageQ : '0;
      ageNext = {1'b0, effAge} + (AGE_W+1)'(1);
      expire  = sampleTick && (activeQ || hit) && ageNext >= {1'b0, winLen};
    end

    always_ff @(posedge clk) begin
      if (!rstN || done || expire) begin
        activeQ <= 1'b0;
        seenQ   <= '0;
        ageQ    <= '0;
      end else if (hit) begin
        activeQ <= 1'b1;
        seenQ   <= newMask;
        ageQ    <= sampleTick ? ageNext[AGE_W-1:0] : effAge;
      end else if (sampleTick && activeQ) begin
        ageQ    <= ageNext[AGE_W-1:0];
      end
    end

    assign doneVec[i] = done;
  end

  always_comb begin
    strobe.viaBypass = rptValid && !shared;
    strobe.fire      = strobe.viaBypass || (|doneVec);
  end
endmodule

// File: rtl/spike_span_validator.sv
module spike_span_validator #(
  parameter int NUM_NEURONS = 8,
  parameter int NUM_FOLDS   = 4,
  parameter int AGE_W       = 4,
  localparam int ID_W   = $clog2(NUM_NEURONS),
  localparam int FOLD_W = $clog2(NUM_FOLDS),
  localparam int SPAN_W = $clog2(NUM_FOLDS),
  localparam int CNT_W  = $clog2(NUM_FOLDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic [AGE_W-1:0]  winLen,
  input  logic              cfgWe,
  input  logic [ID_W-1:0]   cfgId,
  input  logic [SPAN_W-1:0] cfgSpan,
  input  logic              rptValid,
  input  logic [ID_W-1:0]   rptId,
  input  logic [FOLD_W-1:0] rptFold,
  output logic              spkValid,
  output logic [ID_W-1:0]   spkId
);
  spkval_pkg::vldStrobe_t strobe;
  logic [CNT_W-1:0]       needCnt;

  spkval_ctrl #(.NUM_NEURONS(NUM_NEURONS), .NUM_FOLDS(NUM_FOLDS), .AGE_W(AGE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .winLen(winLen),
    .rptValid(rptValid), .rptId(rptId), .rptFold(rptFold),
    .needCnt(needCnt), .strobe(strobe)
  );

  spkval_dpath #(.NUM_NEURONS(NUM_NEURONS), .NUM_FOLDS(NUM_FOLDS)) dpath_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgId(cfgId), .cfgSpan(cfgSpan),
    .rptId(rptId), .strobe(strobe), .needCnt(needCnt),
    .spkValid(spkValid), .spkId(spkId)
  );
endmodule

// File: rtl/spkval_chk.sv
module spkval_chk #(
  parameter int ID_W  = 3,
  parameter int CNT_W = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   rptValid,
  input logic [ID_W-1:0]        rptId,
  input logic [CNT_W-1:0]       needCnt,
  input spkval_pkg::vldStrobe_t strobe,
  input logic                   spkValid,
  input logic [ID_W-1:0]        spkId
);
  AST_OUT_FROM_RPT: assert property (@(posedge clk) disable iff (!rstN)
    spkValid |-> $past(rptValid)); // R4

  AST_ID_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    spkValid |-> spkId == $past(rptId)); // R4

  AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (rptValid && needCnt == CNT_W'(1)) |=> spkValid); // R3

  AST_FIRE_NEEDS_RPT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> rptValid); // R7
endmodule

bind spike_span_validator spkval_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .rptValid(rptValid), .rptId(rptId),
  .needCnt(needCnt), .strobe(strobe), .spkValid(spkValid), .spkId(spkId)
);

// File: tb/spike_span_validator_tb_top.sv
module spike_span_validator_tb_top;
  localparam int NN = 8;
  localparam int NF = 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic [AW-1:0] winLen = AW'(3);
  logic cfgWe = 1'b0;
  logic [2:0] cfgId = '0;
  logic [1:0] cfgSpan = '0;
  logic rptValid = 1'b0;
  logic [2:0] rptId = '0;
  logic [1:0] rptFold = '0;
  logic spkValid;
  logic [2:0] spkId;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R4";

  int mParts [NN];
  int mActive [NN];
  int mMask [NN];
  int mAge [NN];
  int emitCnt [NN];
  bit expV = 1'b0;
  int expId = 0;

  always #4 clk = ~clk;

  spike_span_validator #(.NUM_NEURONS(NN), .NUM_FOLDS(NF), .AGE_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .winLen(winLen),
    .cfgWe(cfgWe), .cfgId(cfgId), .cfgSpan(cfgSpan),
    .rptValid(rptValid), .rptId(rptId), .rptFold(rptFold),
    .spkValid(spkValid), .spkId(spkId)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < NN; n++) begin
        mParts[n] = 1; mActive[n] = 0; mMask[n] = 0; mAge[n] = 0;
      end
      expV = 1'b0;
    end else begin
      expV = 1'b0;
      if (rptValid && mParts[rptId] == 1) begin
        expV = 1'b1; expId = int'(rptId);
      end
      for (int n = 0; n < NN; n++) begin
        bit hit, done, expire;
        int nm, eff;
        hit = rptValid && int'(rptId) == n && mParts[n] > 1;
        nm = mMask[n] | (hit ? (1 << rptFold) : 0);
        done = hit && $countones(nm) >= mParts[n];
        eff = mActive[n] ? mAge[n] : 0;
        expire = sampleTick && (mActive[n] != 0 || hit) && (eff + 1 >= int'(winLen));
        if (done) begin
          expV = 1'b1; expId = n;
        end
        if (done || expire) begin
          mActive[n] = 0; mMask[n] = 0; mAge[n] = 0;
        end else if (hit) begin
          mActive[n] = 1; mMask[n] = nm; mAge[n] = eff + (sampleTick ? 1 : 0);
        end else if (sampleTick && mActive[n] != 0) begin
          mAge[n] = mAge[n] + 1;
        end
      end
      if (cfgWe) mParts[cfgId] = int'(cfgSpan) + 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (spkValid) emitCnt[spkId]++;
      if (expV || spkValid) begin
        checks++;
        if (spkValid !== expV || (expV && spkId !== 3'(expId))) begin
          errors++;
          $display("FAIL %s model: actual v=%0b id=%0d expected v=%0b id=%0d",
                   curReq, spkValid, spkId, expV, expId);
        end
      end
    end
    if (cycles > 5000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below 5000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setSpan(input int id, input int code);
    cfgWe = 1'b1; cfgId = 3'(id); cfgSpan = 2'(code);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic report(input int id, input int fold);
    rptValid = 1'b1; rptId = 3'(id); rptFold = 2'(fold);
    @(negedge clk);
    rptValid = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      sampleTick = 1'b1;
      @(negedge clk);
      sampleTick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    for (int n = 0; n < NN; n++) emitCnt[n] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset spkValid", int'(spkValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'(spkValid), 0);

    // R1: span code 0 after reset gives bypass for neuron 7
    curReq = "R1";
    report(7, 2); idle(1);
    chk("R1 default span bypass", emitCnt[7], 1);

    curReq = "R2";
    setSpan(2, 0); setSpan(3, 1); setSpan(4, 2); setSpan(5, 1); setSpan(6, 3);

    curReq = "R3";
    report(2, 1); idle(1);
    chk("R3 bypass emit", emitCnt[2], 1);

    curReq = "R4";
    report(3, 0); idle(1);
    chk("R4 partial set silent", emitCnt[3], 0);
    report(3, 1); idle(1);
    chk("R4 two-of-two confirm", emitCnt[3], 1);

    curReq = "R8";
    report(4, 0); tick(1); report(4, 2); tick(1); report(4, 3); idle(1);
    chk("R8 across ticks confirm", emitCnt[4], 1);
    chk("R2 span code 2 needs three", emitCnt[4], 1);

    curReq = "R5";
    report(5, 1); report(5, 1); idle(1);
    chk("R5 duplicate fold not counted", emitCnt[5], 0);
    tick(3);
    curReq = "R6";
    report(5, 0); idle(1);
    chk("R6 expired entry cleared", emitCnt[5], 0);
    report(5, 1); idle(1);
    chk("R6 fresh set after expiry", emitCnt[5], 1);

    report(6, 0); tick(1); report(6, 1); tick(1); report(6, 2); tick(1);
    report(6, 3); idle(1);
    chk("R6 window closed before fourth", emitCnt[6], 0);
    tick(3);

    curReq = "R7";
    report(3, 0); report(3, 1); report(3, 0); idle(1);
    chk("R7 single pulse then cleared", emitCnt[3], 2);
    tick(3);

    winLen = AW'(1);
    curReq = "R6";
    report(3, 0); tick(1); report(3, 1); idle(1);
    chk("R6 window of one tick", emitCnt[3], 2);
    tick(1);
    rptValid = 1'b1; rptId = 3'd3; rptFold = 2'd2; sampleTick = 1'b1;
    @(negedge clk);
    rptValid = 1'b0; sampleTick = 1'b0;
    report(3, 0); idle(1);
    chk("R6 report on closing tick then dropped", emitCnt[3], 2);
    tick(1);
    report(3, 2); report(3, 0); idle(1);
    chk("R4 confirm inside one period", emitCnt[3], 3);

    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule